// File: doc/BRIEF.md
# Receive Timeout Supervisor

This block watches a receive session in two stages. When the receive-mode input goes high, a first window opens and waits for a signal-strength detection. A detection happens when the measured level is strictly greater than a programmed threshold. When that happens, the detect flag rises and a second window opens, waiting for a payload-ready pulse. If either window runs out first, the block raises a sticky timeout flag. Software clears that flag with a one-cycle strobe.

Each window's length is an 8-bit value times 16 periods of an external base-period tick. A divide-by-16 prescaler, restarted at the start of every stage, counts the ticks. A programmed value of zero turns that stage's timeout off. The two window values and the threshold sit in three small registers, written through a simple select/data port. The threshold code stands for a level of minus half the code in dBm. The analog level measurement lies outside this block.

Top module: `rx_timeout_sup`

## Requirements
- R1: With first-window value N (N>0) and no detection, `to_flag` rises on the clock edge that samples the (16*N)-th base tick after receive entry, and not before it.
- R2: With second-window value M (M>0), `to_flag` rises on the edge that samples the (16*M)-th tick after the detection edge, unless payload-ready came first.
- R3: A window value of 0 disables that stage, so no timeout ever comes from it.
- R4: After reset, both window registers hold 0 and the threshold holds 0xE4. A write with `wr_en`=1 stores `wr_data` into the register chosen by `wr_sel`: 0 is the threshold, 1 is the first window, 2 is the second window.
- R5: In the first stage, a detection occurs when `rssi_val` > threshold, strictly. On that edge `det_flag` rises; a level equal to the threshold does not count.
- R6: When `rx_on` is low, `det_flag` is cleared on the next edge, the current stage is dropped and counting stops. A later entry restarts from the first stage.
- R7: `to_flag` stays set until a `to_clr` strobe clears it. An expiry in the same cycle as the strobe wins. After a timeout, no further timeout occurs until receive mode is left and entered again.
- R8: The prescaler restarts at each stage start. The ticks seen before a detection do not shorten the second window.
- R9: A payload-ready pulse in the second stage ends the session with no timeout. Payload-ready is ignored in the first stage. A detection on the same edge as a first-window expiry wins, so no timeout is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 threshold, 1 first window, 2 second window |
| wr_data | input | 8 | Register write data |
| rx_on | input | 1 | Receive mode active |
| tick | input | 1 | Base-period tick, one cycle wide |
| rssi_val | input | 8 | Measured signal level code |
| pay_rdy | input | 1 | Payload-ready pulse |
| to_clr | input | 1 | Timeout flag clear strobe |
| det_flag | output | 1 | Signal-strength detected in this session |
| to_flag | output | 1 | Sticky timeout flag |

## Verification
On every cycle the assertions check four things. The detect flag may rise only after a level above the threshold. Leaving receive mode clears detection. The timeout flag is sticky and obeys the clear strobe. A timeout can come only from a window with a nonzero value while in receive mode. The exact window lengths in ticks depend on where detections and payload pulses fall in the session, and so can the restart of the prescaler. The same holds for the tie-break when detection meets expiry, the reset values of the registers and restarting after receive mode is left. The bench's scenarios show these.

// File: rtl/rts_pkg.sv
package rts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_DET = 2'd1,
        ST_WAIT_PAY = 2'd2,
        ST_DONE     = 2'd3
    } rts_state_e;

    localparam logic [1:0] SEL_THR   = 2'd0;
    localparam logic [1:0] SEL_FIRST = 2'd1;
    localparam logic [1:0] SEL_SECND = 2'd2;
endpackage

// File: rtl/rts_cfg_regs.sv
module rts_cfg_regs
    import rts_pkg::*;
#(
    parameter int          VAL_W   = 8,
    parameter logic [VAL_W-1:0] THR_RST = 8'hE4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    output logic [VAL_W-1:0] thr,
    output logic [VAL_W-1:0] win_first,
    output logic [VAL_W-1:0] win_secnd
);
    typedef struct packed {
        logic [VAL_W-1:0] thr;
        logic [VAL_W-1:0] first;
        logic [VAL_W-1:0] secnd;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_THR:   cfg_d.thr   = wr_data;
                SEL_FIRST: cfg_d.first = wr_data;
                SEL_SECND: cfg_d.secnd = wr_data;
                default:   cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.thr   <= THR_RST;
            cfg_q.first <= '0;
            cfg_q.secnd <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign thr       = cfg_q.thr;
    assign win_first = cfg_q.first;
    assign win_secnd = cfg_q.secnd;
endmodule

// File: rtl/rts_window_timer.sv
module rts_window_timer #(
    parameter int VAL_W = 8,
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    input  logic             tick,
    input  logic [VAL_W-1:0] limit,
    output logic             expire
);
    localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [VAL_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic unit_end;

    assign unit_end = run && tick && (tmr_q.pre == PRE_LAST);
    assign expire   = unit_end && (limit != '0) &&
                      (({1'b0, tmr_q.cnt} + 1'b1) == {1'b0, limit});

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d = '0;
        end else if (run && tick) begin
            tmr_d.pre = tmr_q.pre + 1'b1;
            if (unit_end) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end
endmodule

// File: rtl/rx_timeout_sup.sv
module rx_timeout_sup
    import rts_pkg::*;
#(
    parameter int               VAL_W   = 8,
    parameter int               PRE_W   = 4,
    parameter logic [VAL_W-1:0] THR_RST = 8'hE4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [VAL_W-1:0] wr_data,
    input  logic             rx_on,
    input  logic             tick,
    input  logic [VAL_W-1:0] rssi_val,
    input  logic             pay_rdy,
    input  logic             to_clr,
    output logic             det_flag,
    output logic             to_flag
);
    typedef struct packed {
        rts_state_e st;
        logic       det;
        logic       tof;
    } sup_t;

    sup_t sup_d, sup_q;

    logic [VAL_W-1:0] thr_w, first_w, secnd_w, lim_w;
    logic             tmr_restart, tmr_run, tmr_expire, above_w;

    rts_cfg_regs #(.VAL_W(VAL_W), .THR_RST(THR_RST)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .thr       (thr_w),
        .win_first (first_w),
        .win_secnd (secnd_w)
    );

    assign lim_w   = (sup_q.st == ST_WAIT_PAY) ? secnd_w : first_w;
    assign above_w = rssi_val > thr_w;

    rts_window_timer #(.VAL_W(VAL_W), .PRE_W(PRE_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .run     (tmr_run),
        .tick    (tick),
        .limit   (lim_w),
        .expire  (tmr_expire)
    );

    always_comb begin
        sup_d       = sup_q;
        tmr_restart = 1'b0;
        tmr_run     = 1'b0;
        if (to_clr) begin
            sup_d.tof = 1'b0;
        end
        if (!rx_on) begin
            sup_d.st    = ST_IDLE;
            sup_d.det   = 1'b0;
            tmr_restart = 1'b1;
        end else begin
            case (sup_q.st)
                ST_IDLE: begin
                    sup_d.st    = ST_WAIT_DET;
                    tmr_restart = 1'b1;
                end
                ST_WAIT_DET: begin
                    if (above_w) begin
                        sup_d.st    = ST_WAIT_PAY;
                        sup_d.det   = 1'b1;
                        tmr_restart = 1'b1;
                    end else begin
                        tmr_run = (first_w != '0);
                        if (tmr_expire) begin
                            sup_d.tof = 1'b1;
                            sup_d.st  = ST_DONE;
                        end
                    end
                end
                ST_WAIT_PAY: begin
                    if (pay_rdy) begin
                        sup_d.st = ST_DONE;
                    end else begin
                        tmr_run = (secnd_w != '0);
                        if (tmr_expire) begin
                            sup_d.tof = 1'b1;
                            sup_d.st  = ST_DONE;
                        end
                    end
                end
                default: begin
                    sup_d.st = ST_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sup_q.st  <= ST_IDLE;
            sup_q.det <= 1'b0;
            sup_q.tof <= 1'b0;
        end else begin
            sup_q <= sup_d;
        end
    end

    assign det_flag = sup_q.det;
    assign to_flag  = sup_q.tof;
endmodule

// File: rtl/rts_checker.sv
module rts_checker #(
    parameter int VAL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_on,
    input logic             to_clr,
    input logic [VAL_W-1:0] rssi_val,
    input logic [VAL_W-1:0] thr,
    input logic [VAL_W-1:0] lim,
    input logic             expire,
    input logic             det_flag,
    input logic             to_flag
);
    AST_ZERO_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> $past(lim != '0));  // R3

    AST_DETECT_ABOVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_flag) |-> $past(rssi_val > thr));  // R5

    AST_EXIT_CLEARS_DET: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_on |=> !det_flag);  // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (to_flag && !to_clr) |=> to_flag);  // R7

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (to_clr && !expire) |=> !to_flag);  // R7

    AST_TIMEOUT_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(to_flag) |-> $past(rx_on));  // R1
endmodule

bind rx_timeout_sup rts_checker #(.VAL_W(VAL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_on    (rx_on),
    .to_clr   (to_clr),
    .rssi_val (rssi_val),
    .thr      (thr_w),
    .lim      (lim_w),
    .expire   (tmr_expire),
    .det_flag (det_flag),
    .to_flag  (to_flag)
);

// File: tb/tb_rx_timeout_sup.sv
`timescale 1ns/1ps
module tb_rx_timeout_sup;
    logic       clk = 1'b0;
    logic       rst_n, wr_en, rx_on, tick, pay_rdy, to_clr;
    logic [1:0] wr_sel;
    logic [7:0] wr_data, rssi_val;
    logic       det_flag, to_flag;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [7:0] LVL_LO = 8'h10;
    localparam logic [7:0] LVL_HI = 8'hF0;

    // fields: first, second, det_at, pay_at, ticks, exp_to, exp_det
    localparam int NV = 12;
    localparam logic [6:0][15:0] VEC [NV] = '{
        '{16'd1, 16'd0, 16'd0,  16'd0,  16'd15,  16'd0, 16'd0},
        '{16'd1, 16'd0, 16'd0,  16'd0,  16'd16,  16'd1, 16'd0},
        '{16'd2, 16'd0, 16'd0,  16'd0,  16'd31,  16'd0, 16'd0},
        '{16'd2, 16'd0, 16'd0,  16'd0,  16'd32,  16'd1, 16'd0},
        '{16'd0, 16'd5, 16'd0,  16'd0,  16'd100, 16'd0, 16'd0},
        '{16'd2, 16'd1, 16'd10, 16'd0,  16'd25,  16'd0, 16'd1},
        '{16'd2, 16'd1, 16'd10, 16'd0,  16'd26,  16'd1, 16'd1},
        '{16'd2, 16'd1, 16'd10, 16'd20, 16'd60,  16'd0, 16'd1},
        '{16'd1, 16'd0, 16'd5,  16'd0,  16'd200, 16'd0, 16'd1},
        '{16'd1, 16'd1, 16'd16, 16'd0,  16'd31,  16'd0, 16'd1},
        '{16'd1, 16'd1, 16'd16, 16'd0,  16'd32,  16'd1, 16'd1},
        '{16'd1, 16'd0, 16'd0,  16'd8,  16'd16,  16'd1, 16'd0}
    };

    rx_timeout_sup dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rx_on(rx_on), .tick(tick), .rssi_val(rssi_val),
        .pay_rdy(pay_rdy), .to_clr(to_clr), .det_flag(det_flag), .to_flag(to_flag)
    );

    always #2 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            step();
        end
        tick = 1'b0;
    endtask

    task automatic clear_flag();
        to_clr = 1'b1;
        step();
        to_clr = 1'b0;
    endtask

    task automatic enter_rx();
        rx_on = 1'b1;
        tick = 1'b0;
        step();
    endtask

    task automatic leave_rx();
        rx_on = 1'b0;
        tick = 1'b0;
        pay_rdy = 1'b0;
        step();
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_data = 8'd0;
        rx_on = 1'b0; tick = 1'b0; rssi_val = LVL_LO; pay_rdy = 1'b0; to_clr = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // Reset state
        check("R4 reset det_flag", det_flag, 1'b0);
        check("R4 reset to_flag", to_flag, 1'b0);

        // R4: both windows reset to 0, so no timeout; threshold resets to 0xE4
        enter_rx();
        ticks(300);
        check("R4 windows reset disabled", to_flag, 1'b0);
        rssi_val = 8'hE4;
        step(); step();
        check("R5 equal to reset threshold 0xE4", det_flag, 1'b0);
        rssi_val = 8'hE5;
        step();
        check("R5 above reset threshold 0xE4", det_flag, 1'b1);
        rssi_val = LVL_LO;
        leave_rx();
        check("R6 leave clears det", det_flag, 1'b0);

        // R4/R5: new threshold through select 0
        wr(2'd0, 8'h80);
        enter_rx();
        rssi_val = 8'h80;
        step(); step();
        check("R5 equal to written threshold", det_flag, 1'b0);
        rssi_val = 8'h81;
        step();
        check("R5 above written threshold", det_flag, 1'b1);
        rssi_val = LVL_LO;
        leave_rx();

        // Vector table
        for (int v = 0; v < NV; v++) begin
            wr(2'd1, VEC[v][6][7:0]);
            wr(2'd2, VEC[v][5][7:0]);
            clear_flag();
            enter_rx();
            for (int i = 1; i <= int'(VEC[v][2]); i++) begin
                tick = 1'b1;
                rssi_val = (VEC[v][4] != 0 && i >= int'(VEC[v][4])) ? LVL_HI : LVL_LO;
                pay_rdy = (i == int'(VEC[v][3]));
                step();
            end
            tick = 1'b0; pay_rdy = 1'b0;
            check($sformatf("R1/R2/R3/R8/R9 vector %0d to_flag", v), to_flag, VEC[v][1][0]);
            check($sformatf("R5 vector %0d det_flag", v), det_flag, VEC[v][0][0]);
            rssi_val = LVL_LO;
            leave_rx();
        end

        // R6/R8: leaving mid-session drops the stage; re-entry restarts the window
        wr(2'd1, 8'd2);
        wr(2'd2, 8'd2);
        clear_flag();
        enter_rx();
        ticks(4);
        rssi_val = LVL_HI;
        ticks(20);
        rssi_val = LVL_LO;
        check("R6 det before exit", det_flag, 1'b1);
        leave_rx();
        check("R6 det cleared on exit", det_flag, 1'b0);
        ticks(50);
        check("R6 no timeout while out of rx", to_flag, 1'b0);
        enter_rx();
        ticks(31);
        check("R6 restarted window not yet expired", to_flag, 1'b0);
        ticks(1);
        check("R6 restarted window expired at 32", to_flag, 1'b1);

        // R7: sticky
        ticks(40);
        check("R7 sticky in rx", to_flag, 1'b1);
        leave_rx();
        check("R7 sticky after exit", to_flag, 1'b1);
        clear_flag();
        check("R7 clear strobe", to_flag, 1'b0);

        // R7: no counting after timeout until re-entry
        wr(2'd1, 8'd1);
        enter_rx();
        ticks(16);
        check("R7 timeout for stop test", to_flag, 1'b1);
        clear_flag();
        ticks(40);
        check("R7 no second timeout in same session", to_flag, 1'b0);
        leave_rx();

        // R7: expiry wins over clear in same cycle
        enter_rx();
        ticks(15);
        tick = 1'b1; to_clr = 1'b1;
        step();
        tick = 1'b0; to_clr = 1'b0;
        check("R7 set wins over clear", to_flag, 1'b1);
        leave_rx();
        clear_flag();

        // R4: select 3 writes nothing
        wr(2'd3, 8'd1);
        wr(2'd1, 8'd0);
        wr(2'd3, 8'd1);
        enter_rx();
        ticks(40);
        check("R4 unused select leaves first window at 0", to_flag, 1'b0);
        leave_rx();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule